// File: doc/BRIEF.md
# Bus-Error Capture Monitor

This block sits beside the master side of a bus bridge and watches the transfers the bridge issues on its destination bus. When a destination slave ends a transfer with the two-cycle ERROR response, the block raises an interrupt. It also records what the failing transfer was: its full address, whether it was a write, its size, its burst type and the response code. A master that posted a write and moved on can learn from this record that the write never landed.

The record is read through a small AHB-style register port. That port is selected by its own register-select input rather than by the normal slave select. Reads have no side effects. Software clears the record and drops the interrupt by writing a 1 to bit 0 of the status word. Only the first error is kept. Any error that arrives while a record is held only sets a sticky overflow flag.

Top module: `buserr_capture`

## Requirements
- R1: An error is recognised only in the first cycle of an ERROR response (mon_hresp = 2'b01 with mon_hready low) during the data phase of a transfer whose address phase was accepted. OKAY (2'b00), RETRY (2'b10) and SPLIT (2'b11) responses never raise the interrupt.
- R2: bus_err_irq is low during the first ERROR cycle and is high from the clock edge that ends it, so it is already asserted in the second ERROR cycle.
- R3: The status word reads as follows. Bit 0 is the write flag, bits 3:1 the transfer size and bits 6:4 the burst type. Bits 8:7 hold the response code, bit 9 is the valid flag and bit 10 the overflow flag; the other bits read zero. The attributes come from the address phase that belongs to the failing data phase, not from the address phase on the bus while the error is signalled.
- R4: The address register returns the full 32-bit address of the failing transfer.
- R5: The record and the interrupt stay unchanged until they are cleared, and reading either register changes nothing.
- R6: An error that arrives while a record is held leaves the attributes and the address unchanged and sets the overflow bit (bit 10). That bit stays set until a clear.
- R7: A write to the status offset with bit 0 of the write data set clears the whole record and drops bus_err_irq at the clock edge that ends the write data phase. The same write with bit 0 clear has no effect, and so does any write to the address offset.
- R8: A register access is accepted when reg_sel is high, reg_htrans[1] is high and reg_hready is high. reg_haddr[2] picks the register: 0 for status, 1 for address. For a read, reg_hrdata carries the value from the clock edge that ends the address phase and holds it until the next accepted read.
- R9: After reset bus_err_irq is low, reg_hrdata is zero and both registers read zero.
- R10: An address phase whose mon_htrans[1] is low (IDLE or BUSY) opens no data phase, so an ERROR-shaped response after it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Destination-bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_htrans | input | 2 | Observed transfer type |
| mon_haddr | input | 32 | Observed address |
| mon_hwrite | input | 1 | Observed write flag |
| mon_hsize | input | 3 | Observed transfer size |
| mon_hburst | input | 3 | Observed burst type |
| mon_hready | input | 1 | Observed transfer-done strobe |
| mon_hresp | input | 2 | Observed slave response |
| reg_sel | input | 1 | Register-port select |
| reg_htrans | input | 2 | Register-port transfer type |
| reg_hwrite | input | 1 | Register-port write flag |
| reg_haddr | input | 3 | Register-port byte offset |
| reg_hready | input | 1 | Register-port ready input |
| reg_hwdata | input | 32 | Register-port write data |
| reg_hrdata | output | 32 | Register-port read data |
| bus_err_irq | output | 1 | Bus-error interrupt |

## Verification
The interrupt is due one clock edge after the first ERROR cycle. The bench samples it just after the edge that ends the first ERROR cycle and also just before that edge, where it must still be low. Read data is due at the edge that ends the register address phase, and the bench samples it just after that edge. A clear takes effect at the edge that ends the write data phase, so the bench checks the interrupt and then rereads the registers after that edge. During every error the bench drives a decoy address phase with different attributes, to show that the capture comes from the older address phase.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] RESP_ERROR = 2'b01;
  localparam int SIZE_W  = 3;
  localparam int BURST_W = 3;

  // Packed MSB-first: write flag lands at bit 0 of the status word.
  typedef struct packed {
    logic               ovf;
    logic               valid;
    logic [1:0]         resp;
    logic [BURST_W-1:0] burst;
    logic [SIZE_W-1:0]  size;
    logic               write;
  } err_attr_t;

  localparam int STATUS_W = $bits(err_attr_t);
endpackage

// File: rtl/buserr_aphase.sv
module buserr_aphase
  import buserr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mon_tr_active,
  input  logic [ADDR_W-1:0]  mon_haddr,
  input  logic               mon_hwrite,
  input  logic [SIZE_W-1:0]  mon_hsize,
  input  logic [BURST_W-1:0] mon_hburst,
  input  logic               mon_hready,
  output logic               dp_valid,
  output logic [ADDR_W-1:0]  dp_addr,
  output logic               dp_write,
  output logic [SIZE_W-1:0]  dp_size,
  output logic [BURST_W-1:0] dp_burst
);
  // Address phase is held across wait states until its data phase ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      dp_valid <= 1'b0;
      dp_addr  <= '0;
      dp_write <= 1'b0;
      dp_size  <= '0;
      dp_burst <= '0;
    end else if (mon_hready) begin
      dp_valid <= mon_tr_active;
      if (mon_tr_active) begin
        dp_addr  <= mon_haddr;
        dp_write <= mon_hwrite;
        dp_size  <= mon_hsize;
        dp_burst <= mon_hburst;
      end
    end
  end
endmodule

// File: rtl/buserr_latch.sv
module buserr_latch
  import buserr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dp_valid,
  input  logic [ADDR_W-1:0]  dp_addr,
  input  logic               dp_write,
  input  logic [SIZE_W-1:0]  dp_size,
  input  logic [BURST_W-1:0] dp_burst,
  input  logic               mon_hready,
  input  logic [1:0]         mon_hresp,
  input  logic               clr_req,
  output err_attr_t          attr,
  output logic [ADDR_W-1:0]  err_addr,
  output logic               irq
);
  logic err_first;
  logic held;

  assign err_first = dp_valid && (mon_hresp == RESP_ERROR) && !mon_hready;
  assign held      = attr.valid && !clr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      attr     <= '0;
      err_addr <= '0;
      irq      <= 1'b0;
    end else begin
      if (clr_req) begin
        attr     <= '0;
        err_addr <= '0;
        irq      <= 1'b0;
      end
      if (err_first) begin
        if (held) begin
          attr.ovf <= 1'b1;
        end else begin
          attr.ovf   <= 1'b0;
          attr.valid <= 1'b1;
          attr.resp  <= mon_hresp;
          attr.burst <= dp_burst;
          attr.size  <= dp_size;
          attr.write <= dp_write;
          err_addr   <= dp_addr;
          irq        <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/buserr_regport.sv
module buserr_regport
  import buserr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_tr_active,
  input  logic              reg_hwrite,
  input  logic              reg_ofs,
  input  logic              reg_hready,
  input  logic              reg_wbit0,
  input  err_attr_t         attr,
  input  logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] reg_hrdata,
  output logic              clr_req
);
  logic acc;
  logic wr_pend;
  logic wr_ofs;

  assign acc     = reg_sel && reg_tr_active && reg_hready;
  assign clr_req = wr_pend && reg_hready && !wr_ofs && reg_wbit0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend    <= 1'b0;
      wr_ofs     <= 1'b0;
      reg_hrdata <= '0;
    end else if (reg_hready) begin
      wr_pend <= acc && reg_hwrite;
      wr_ofs  <= reg_ofs;
      if (acc && !reg_hwrite)
        reg_hrdata <= reg_ofs ? DATA_W'(err_addr) : DATA_W'(attr);
    end
  end
endmodule

// File: rtl/buserr_capture.sv
module buserr_capture
  import buserr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mon_htrans,
  input  logic [ADDR_W-1:0]  mon_haddr,
  input  logic               mon_hwrite,
  input  logic [SIZE_W-1:0]  mon_hsize,
  input  logic [BURST_W-1:0] mon_hburst,
  input  logic               mon_hready,
  input  logic [1:0]         mon_hresp,
  input  logic               reg_sel,
  input  logic [1:0]         reg_htrans,
  input  logic               reg_hwrite,
  input  logic [REG_AW-1:0]  reg_haddr,
  input  logic               reg_hready,
  input  logic [DATA_W-1:0]  reg_hwdata,
  output logic [DATA_W-1:0]  reg_hrdata,
  output logic               bus_err_irq
);
  localparam int OFS_BIT = REG_AW - 1;

  logic               dp_valid;
  logic [ADDR_W-1:0]  dp_addr;
  logic               dp_write;
  logic [SIZE_W-1:0]  dp_size;
  logic [BURST_W-1:0] dp_burst;
  err_attr_t          attr;
  logic [ADDR_W-1:0]  err_addr;
  logic               clr_req;
  logic               unused_bits;

  assign unused_bits = ^{mon_htrans[0], reg_htrans[0],
                         reg_haddr[OFS_BIT-1:0], reg_hwdata[DATA_W-1:1]};

  buserr_aphase #(.ADDR_W(ADDR_W)) u_aphase (
    .clk(clk), .rst(rst), .mon_tr_active(mon_htrans[1]),
    .mon_haddr(mon_haddr), .mon_hwrite(mon_hwrite), .mon_hsize(mon_hsize),
    .mon_hburst(mon_hburst), .mon_hready(mon_hready),
    .dp_valid(dp_valid), .dp_addr(dp_addr), .dp_write(dp_write),
    .dp_size(dp_size), .dp_burst(dp_burst)
  );

  buserr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst(rst), .dp_valid(dp_valid), .dp_addr(dp_addr),
    .dp_write(dp_write), .dp_size(dp_size), .dp_burst(dp_burst),
    .mon_hready(mon_hready), .mon_hresp(mon_hresp), .clr_req(clr_req),
    .attr(attr), .err_addr(err_addr), .irq(bus_err_irq)
  );

  buserr_regport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regport (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_tr_active(reg_htrans[1]),
    .reg_hwrite(reg_hwrite), .reg_ofs(reg_haddr[OFS_BIT]),
    .reg_hready(reg_hready), .reg_wbit0(reg_hwdata[0]),
    .attr(attr), .err_addr(err_addr), .reg_hrdata(reg_hrdata),
    .clr_req(clr_req)
  );
endmodule

// File: rtl/buserr_capture_chk.sv
module buserr_capture_chk
  import buserr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mon_hresp,
  input logic              mon_hready,
  input logic              dp_valid,
  input logic              clr_req,
  input logic              ovf,
  input logic [ADDR_W-1:0] err_addr,
  input logic              bus_err_irq
);
  p_err_raises_irq_r2: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && mon_hresp == RESP_ERROR && !mon_hready) |=> bus_err_irq);

  p_irq_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_err_irq) |-> ($past(mon_hresp) == RESP_ERROR && !$past(mon_hready)));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_err_irq && !clr_req) |=> bus_err_irq);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_err_irq && !clr_req) |=> $stable(err_addr));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_req) |=> ovf);

  p_ovf_needs_irq_r6: assert property (@(posedge clk) disable iff (rst)
    ovf |-> bus_err_irq);

  p_clear_drops_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> !ovf);
endmodule

bind buserr_capture buserr_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mon_hresp(mon_hresp), .mon_hready(mon_hready),
  .dp_valid(dp_valid), .clr_req(clr_req), .ovf(attr.ovf),
  .err_addr(err_addr), .bus_err_irq(bus_err_irq)
);

// File: tb/buserr_capture_test.sv
module buserr_capture_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mon_htrans = 2'b00;
  logic [31:0] mon_haddr = '0;
  logic        mon_hwrite = 1'b0;
  logic [2:0]  mon_hsize = '0;
  logic [2:0]  mon_hburst = '0;
  logic        mon_hready = 1'b1;
  logic [1:0]  mon_hresp = 2'b00;
  logic        reg_sel = 1'b0;
  logic [1:0]  reg_htrans = 2'b00;
  logic        reg_hwrite = 1'b0;
  logic [2:0]  reg_haddr = '0;
  logic        reg_hready = 1'b1;
  logic [31:0] reg_hwdata = '0;
  logic [31:0] reg_hrdata;
  logic        bus_err_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  buserr_capture uut (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [2:0]  size;
    logic [2:0]  burst;
    logic [1:0]  resp;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{addr: 32'h4000_0010, wr: 1'b1, size: 3'd2, burst: 3'd3, resp: 2'b01},
    '{addr: 32'h1234_5678, wr: 1'b0, size: 3'd2, burst: 3'd1, resp: 2'b00},
    '{addr: 32'hFFFF_FFFC, wr: 1'b0, size: 3'd0, burst: 3'd4, resp: 2'b01},
    '{addr: 32'h0000_0100, wr: 1'b1, size: 3'd1, burst: 3'd0, resp: 2'b10},
    '{addr: 32'h8000_0002, wr: 1'b1, size: 3'd1, burst: 3'd0, resp: 2'b01},
    '{addr: 32'h0BAD_0000, wr: 1'b0, size: 3'd2, burst: 3'd7, resp: 2'b11}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] status_of(input vec_t v, input logic ovf);
    return {21'd0, ovf, 1'b1, 2'b01, v.burst, v.size, v.wr};
  endfunction

  task automatic reg_read(input logic [2:0] ofs, output logic [31:0] data);
    reg_sel = 1'b1; reg_htrans = 2'b10; reg_hwrite = 1'b0; reg_haddr = ofs;
    tick();
    data = reg_hrdata;
    reg_sel = 1'b0; reg_htrans = 2'b00;
  endtask

  task automatic reg_write(input logic [2:0] ofs, input logic [31:0] data);
    reg_sel = 1'b1; reg_htrans = 2'b10; reg_hwrite = 1'b1; reg_haddr = ofs;
    tick();
    reg_sel = 1'b0; reg_htrans = 2'b00; reg_hwrite = 1'b0; reg_hwdata = data;
    tick();
    reg_hwdata = '0;
  endtask

  // Address phase, then a two-cycle response with a decoy address phase pending.
  task automatic bus_xfer(input vec_t v, input logic [1:0] aph_trans,
                          output logic irq_first, output logic irq_second);
    mon_htrans = aph_trans; mon_haddr = v.addr; mon_hwrite = v.wr;
    mon_hsize = v.size; mon_hburst = v.burst; mon_hready = 1'b1; mon_hresp = 2'b00;
    tick();
    mon_htrans = 2'b10; mon_haddr = v.addr ^ 32'hFFFF_0000; mon_hwrite = ~v.wr;
    mon_hsize = v.size ^ 3'd1; mon_hburst = v.burst ^ 3'd1;
    mon_hready = 1'b0; mon_hresp = v.resp;
    irq_first = bus_err_irq;
    tick();
    irq_second = bus_err_irq;
    mon_hready = 1'b1;
    tick();
    mon_htrans = 2'b00; mon_hresp = 2'b00;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2, st_x, ad_x;
    logic i1, i2;
    vec_t vx, vy;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R9 reset state
    check("R9 irq after reset", {31'd0, bus_err_irq}, 32'd0);
    check("R9 hrdata after reset", reg_hrdata, 32'd0);
    reg_read(3'd0, rd); check("R9 status after reset", rd, 32'd0);
    reg_read(3'd4, rd); check("R9 address after reset", rd, 32'd0);

    // Table walk: R1 R2 R3 R4 R8
    for (int k = 0; k < 6; k++) begin
      reg_write(3'd0, 32'd1);
      bus_xfer(VEC[k], 2'b10, i1, i2);
      check($sformatf("R2 irq low in first cycle v%0d", k), {31'd0, i1}, 32'd0);
      check($sformatf("R1 R2 irq in second cycle v%0d", k), {31'd0, i2},
            {31'd0, VEC[k].resp == 2'b01});
      reg_read(3'd0, rd);
      check($sformatf("R3 R8 status v%0d", k), rd,
            VEC[k].resp == 2'b01 ? status_of(VEC[k], 1'b0) : 32'd0);
      reg_read(3'd4, rd);
      check($sformatf("R4 R8 address v%0d", k), rd,
            VEC[k].resp == 2'b01 ? VEC[k].addr : 32'd0);
    end

    // R10 IDLE address phase then ERROR-shaped response
    reg_write(3'd0, 32'd1);
    vx = '{addr: 32'h5555_0000, wr: 1'b1, size: 3'd2, burst: 3'd2, resp: 2'b01};
    bus_xfer(vx, 2'b00, i1, i2);
    check("R10 idle phase ignored irq", {31'd0, i2}, 32'd0);
    reg_read(3'd0, rd); check("R10 idle phase ignored status", rd, 32'd0);

    // R5 capture and side-effect-free reads
    vx = '{addr: 32'hA5A5_1234, wr: 1'b0, size: 3'd1, burst: 3'd5, resp: 2'b01};
    bus_xfer(vx, 2'b11, i1, i2);
    st_x = status_of(vx, 1'b0);
    reg_read(3'd0, rd); reg_read(3'd0, rd2);
    check("R5 status first read", rd, st_x);
    check("R5 status second read", rd2, st_x);
    check("R5 irq held after reads", {31'd0, bus_err_irq}, 32'd1);
    tick(); tick();
    check("R8 hrdata held while idle", reg_hrdata, st_x);

    // R6 second error sets overflow only
    vy = '{addr: 32'h0F0F_0F00, wr: 1'b1, size: 3'd2, burst: 3'd1, resp: 2'b01};
    bus_xfer(vy, 2'b10, i1, i2);
    check("R6 irq still high", {31'd0, i2}, 32'd1);
    reg_read(3'd0, rd); check("R6 status with overflow", rd, status_of(vx, 1'b1));
    reg_read(3'd4, ad_x); check("R6 address unchanged", ad_x, vx.addr);

    // R7 clear rules
    reg_write(3'd0, 32'hFFFF_FFFE);
    check("R7 bit0 clear write ignored irq", {31'd0, bus_err_irq}, 32'd1);
    reg_read(3'd0, rd); check("R7 bit0 clear write ignored status", rd, status_of(vx, 1'b1));
    reg_write(3'd4, 32'd1);
    check("R7 address-offset write ignored", {31'd0, bus_err_irq}, 32'd1);
    reg_read(3'd4, rd); check("R7 address kept", rd, vx.addr);
    reg_write(3'd0, 32'd1);
    check("R7 clear drops irq", {31'd0, bus_err_irq}, 32'd0);
    reg_read(3'd0, rd); check("R7 status cleared", rd, 32'd0);
    reg_read(3'd4, rd); check("R7 address cleared", rd, 32'd0);

    // R6 overflow gone after clear: fresh capture
    bus_xfer(vy, 2'b10, i1, i2);
    reg_read(3'd0, rd); check("R6 fresh capture after clear", rd, status_of(vy, 1'b0));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule